// File: doc/BRIEF.md
# Same-Address Collision Arbiter for a Two-Port Memory

This block watches the two ports of a shared memory array. Each cycle it takes, for each port, a request strobe, a write flag, an address and the timestamp of that port's active clock edge. The timestamp is a tick count of a time base common to both ports. When both ports hit the same address, the signed gap between the two edge timestamps is compared with a setup window. The outcome is deterministic: the block gates the array's write enables, tells each reader whether its data is the old contents, the new contents or not guaranteed, and pulls an active-low busy flag on the port that lost.

The setup window is held in two tick-count settings, one for a port running single-rate and one for a port running double-rate. A write/read collision uses the writer's window. A write/write collision uses the wider of the two ports' windows. All outputs are registered, so they show the request sampled at the previous clock edge.

Top module: `colarb_top`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs go to idle values: both busy flags 1, both write enables 0, both read selects 0 (plain read), `wr_corrupt` 0.
- R2: With no same-address pair (a port idle, or the addresses differ), each write enable equals that port's `vld & wr`, busy flags stay 1, read selects are 0 and `wr_corrupt` is 0.
- R3: Two reads of the same address are not a collision: busy flags 1, read selects 0.
- R4: In a write/read collision where the reader's timestamp exceeds the writer's by more than the window, the reader's select is 2 (new data), its busy flag stays 1, and the writer's write enable stays 1.
- R5: In a write/read collision where the reader's timestamp is more than the window below the writer's, the reader's select is 1 (old data) and no busy flag is asserted.
- R6: In a write/read collision with an absolute timestamp gap no larger than the window (equality included), the reader's select is 3 (not guaranteed) and the reader's busy flag is 0. The writer's write enable stays 1.
- R7: In a write/read collision, the window is `win_ddr` when the writer's `ddr` bit is 1 and `win_sdr` otherwise.
- R8: In a write/write collision with a gap larger than the window, only the later port's write enable stays 1, and the earlier port's busy flag is 0.
- R9: In a write/write collision with a gap no larger than the window, both write enables are 0, both busy flags are 0, and `wr_corrupt` is 1.
- R10: In a write/write collision the window is the larger of the two ports' windows, each chosen by that port's `ddr` bit.
- R11: Outputs change one clock after the request is sampled. A busy flag returns to 1 on the cycle after its collision when the next request does not collide.
- R12: The timestamp gap is taken modulo 2^TS_W as a signed value, so that edges on either side of a counter wrap compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| win_sdr | input | WIN_W | Setup window in ticks for a single-rate port |
| win_ddr | input | WIN_W | Setup window in ticks for a double-rate port |
| a_vld | input | 1 | Port A access this cycle |
| a_wr | input | 1 | Port A access is a write |
| a_ddr | input | 1 | Port A runs double-rate |
| a_addr | input | ADDR_W | Port A address |
| a_ts | input | TS_W | Port A edge timestamp in ticks |
| b_vld | input | 1 | Port B access this cycle |
| b_wr | input | 1 | Port B access is a write |
| b_ddr | input | 1 | Port B runs double-rate |
| b_addr | input | ADDR_W | Port B address |
| b_ts | input | TS_W | Port B edge timestamp in ticks |
| a_busy_n | output | 1 | Port A busy, active low |
| b_busy_n | output | 1 | Port B busy, active low |
| a_we | output | 1 | Gated write enable for port A |
| b_we | output | 1 | Gated write enable for port B |
| a_rsel | output | 2 | Port A read select: 0 plain, 1 old, 2 new, 3 not guaranteed |
| b_rsel | output | 2 | Port B read select, same coding |
| wr_corrupt | output | 1 | Write/write collision inside the window |

## Verification
The block keeps no state beyond its output register. A wrong window choice, a wrong gap sign or a bad wrap shows at the ports within one clock as a swapped old/new select, a busy flag on the wrong port, or a write enable that is kept when it should be gated. Busy flags held too long show on the following idle cycle. The corners that matter are a gap exactly equal to the window, a gap one tick past it, a double-rate writer and timestamps that straddle the wrap.

// File: rtl/colarb_pkg.sv
package colarb_pkg;

  typedef enum logic [1:0] {
    RD_PLAIN = 2'd0,
    RD_OLD   = 2'd1,
    RD_NEW   = 2'd2,
    RD_UNDEF = 2'd3
  } rd_sel_e;

  // position of port A's edge relative to port B's edge
  typedef enum logic [1:0] {
    EDGE_EARLY = 2'd0,
    EDGE_LATE  = 2'd1,
    EDGE_NEAR  = 2'd2
  } edge_cls_e;

  typedef struct packed {
    logic    busy_a_n;
    logic    busy_b_n;
    logic    we_a;
    logic    we_b;
    logic    corrupt;
    rd_sel_e rsel_a;
    rd_sel_e rsel_b;
  } arb_out_t;

  localparam arb_out_t ARB_IDLE = '{busy_a_n: 1'b1, busy_b_n: 1'b1, we_a: 1'b0,
                                    we_b: 1'b0, corrupt: 1'b0,
                                    rsel_a: RD_PLAIN, rsel_b: RD_PLAIN};

endpackage

// File: rtl/colarb_window.sv
module colarb_window #(
  parameter int WIN_W  = 12,
  parameter bit DDR_EN = 1'b1
) (
  input  logic             ddr,
  input  logic [WIN_W-1:0] win_sdr,
  input  logic [WIN_W-1:0] win_ddr,
  output logic [WIN_W-1:0] win
);
  generate
    if (DDR_EN) begin : g_dual
      assign win = ddr ? win_ddr : win_sdr;
    end else begin : g_single
      logic unused_ddr;
      assign unused_ddr = ddr ^ (^win_ddr);
      assign win = win_sdr;
    end
  endgenerate
endmodule

// File: rtl/colarb_edge_cmp.sv
module colarb_edge_cmp
  import colarb_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int WIN_W = 12
) (
  input  logic [TS_W-1:0]  ts_a,
  input  logic [TS_W-1:0]  ts_b,
  input  logic [WIN_W-1:0] win,
  output edge_cls_e        cls
);
  localparam int EXT_W = TS_W + 1;
  localparam int PAD_W = EXT_W - WIN_W;

  logic [TS_W-1:0]         gap_mod;
  logic signed [EXT_W-1:0] gap;
  logic signed [EXT_W-1:0] lim_hi;
  logic signed [EXT_W-1:0] lim_lo;

  always_comb begin
    gap_mod = ts_a - ts_b;
    gap     = $signed({gap_mod[TS_W-1], gap_mod});
    lim_hi  = $signed({{PAD_W{1'b0}}, win});
    lim_lo  = -lim_hi;
    if (gap > lim_hi)      cls = EDGE_LATE;
    else if (gap < lim_lo) cls = EDGE_EARLY;
    else                   cls = EDGE_NEAR;
  end
endmodule

// File: rtl/colarb_decode.sv
module colarb_decode
  import colarb_pkg::*;
(
  input  logic      vld_a,
  input  logic      wr_a,
  input  logic      vld_b,
  input  logic      wr_b,
  input  logic      same_addr,
  input  edge_cls_e cls,
  output arb_out_t  res
);
  logic hit;

  always_comb begin
    hit = vld_a & vld_b & same_addr;
    res = ARB_IDLE;
    res.we_a = vld_a & wr_a;
    res.we_b = vld_b & wr_b;
    if (hit) begin
      unique case ({wr_a, wr_b})
        2'b01: begin
          unique case (cls)
            EDGE_LATE:  res.rsel_a = RD_NEW;
            EDGE_EARLY: res.rsel_a = RD_OLD;
            default: begin
              res.rsel_a   = RD_UNDEF;
              res.busy_a_n = 1'b0;
            end
          endcase
        end
        2'b10: begin
          unique case (cls)
            EDGE_EARLY: res.rsel_b = RD_NEW;
            EDGE_LATE:  res.rsel_b = RD_OLD;
            default: begin
              res.rsel_b   = RD_UNDEF;
              res.busy_b_n = 1'b0;
            end
          endcase
        end
        2'b11: begin
          unique case (cls)
            EDGE_LATE: begin
              res.we_b     = 1'b0;
              res.busy_b_n = 1'b0;
            end
            EDGE_EARLY: begin
              res.we_a     = 1'b0;
              res.busy_a_n = 1'b0;
            end
            default: begin
              res.we_a     = 1'b0;
              res.we_b     = 1'b0;
              res.busy_a_n = 1'b0;
              res.busy_b_n = 1'b0;
              res.corrupt  = 1'b1;
            end
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/colarb_top.sv
module colarb_top
  import colarb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TS_W   = 16,
  parameter int WIN_W  = 12,
  parameter bit DDR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_W-1:0]  win_sdr,
  input  logic [WIN_W-1:0]  win_ddr,
  input  logic              a_vld,
  input  logic              a_wr,
  input  logic              a_ddr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [TS_W-1:0]   a_ts,
  input  logic              b_vld,
  input  logic              b_wr,
  input  logic              b_ddr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [TS_W-1:0]   b_ts,
  output logic              a_busy_n,
  output logic              b_busy_n,
  output logic              a_we,
  output logic              b_we,
  output logic [1:0]        a_rsel,
  output logic [1:0]        b_rsel,
  output logic              wr_corrupt
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]            port_ddr;
  logic [NPORT-1:0][WIN_W-1:0] port_win;
  logic [WIN_W-1:0]            win_sel;
  edge_cls_e                   cls;
  arb_out_t                    nxt;
  arb_out_t                    q;

  assign port_ddr = {b_ddr, a_ddr};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    colarb_window #(.WIN_W(WIN_W), .DDR_EN(DDR_EN)) u_win (
      .ddr     (port_ddr[p]),
      .win_sdr (win_sdr),
      .win_ddr (win_ddr),
      .win     (port_win[p])
    );
  end

  // writer's window for write/read, wider window for write/write
  always_comb begin
    unique case ({a_wr, b_wr})
      2'b10:   win_sel = port_win[0];
      2'b01:   win_sel = port_win[1];
      2'b11:   win_sel = (port_win[0] > port_win[1]) ? port_win[0] : port_win[1];
      default: win_sel = win_sdr;
    endcase
  end

  colarb_edge_cmp #(.TS_W(TS_W), .WIN_W(WIN_W)) u_cmp (
    .ts_a (a_ts),
    .ts_b (b_ts),
    .win  (win_sel),
    .cls  (cls)
  );

  colarb_decode u_dec (
    .vld_a     (a_vld),
    .wr_a      (a_wr),
    .vld_b     (b_vld),
    .wr_b      (b_wr),
    .same_addr (a_addr == b_addr),
    .cls       (cls),
    .res       (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= ARB_IDLE;
    else     q <= nxt;
  end

  assign a_busy_n   = q.busy_a_n;
  assign b_busy_n   = q.busy_b_n;
  assign a_we       = q.we_a;
  assign b_we       = q.we_b;
  assign a_rsel     = q.rsel_a;
  assign b_rsel     = q.rsel_b;
  assign wr_corrupt = q.corrupt;
endmodule

// File: rtl/colarb_checker.sv
module colarb_checker (
  input logic       clk,
  input logic       rst,
  input logic       a_vld,
  input logic       b_vld,
  input logic       a_busy_n,
  input logic       b_busy_n,
  input logic       a_we,
  input logic       b_we,
  input logic [1:0] a_rsel,
  input logic [1:0] b_rsel,
  input logic       wr_corrupt
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (a_busy_n && b_busy_n && !a_we && !b_we && !wr_corrupt));

  a_r9_corrupt_gates_all: assert property (@(posedge clk) disable iff (rst)
    wr_corrupt |-> (!a_we && !b_we && !a_busy_n && !b_busy_n));

  a_r9_double_busy_is_corrupt: assert property (@(posedge clk) disable iff (rst)
    (!a_busy_n && !b_busy_n) |-> wr_corrupt);

  a_r6_undef_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (a_rsel == 2'd3) |-> (!a_busy_n && b_we));

  a_r4_resolved_read_clean: assert property (@(posedge clk) disable iff (rst)
    (b_rsel == 2'd1 || b_rsel == 2'd2) |-> (b_busy_n && a_busy_n && a_we));

  a_r11_idle_port_not_busy: assert property (@(posedge clk) disable iff (rst)
    !$past(a_vld) |-> a_busy_n);
endmodule

bind colarb_top colarb_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_vld      (a_vld),
  .b_vld      (b_vld),
  .a_busy_n   (a_busy_n),
  .b_busy_n   (b_busy_n),
  .a_we       (a_we),
  .b_we       (b_we),
  .a_rsel     (a_rsel),
  .b_rsel     (b_rsel),
  .wr_corrupt (wr_corrupt)
);

// File: tb/sim_colarb_top.sv
module sim_colarb_top;
  localparam int ADDR_W = 10;
  localparam int TS_W   = 16;
  localparam int WIN_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WIN_W-1:0] win_sdr = 12'd10;
  logic [WIN_W-1:0] win_ddr = 12'd25;
  logic a_vld = 0, a_wr = 0, a_ddr = 0, b_vld = 0, b_wr = 0, b_ddr = 0;
  logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
  logic [TS_W-1:0] a_ts = '0, b_ts = '0;
  logic a_busy_n, b_busy_n, a_we, b_we, wr_corrupt;
  logic [1:0] a_rsel, b_rsel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [10:0] exp_v;

  always #2 clk = ~clk;

  colarb_top #(.ADDR_W(ADDR_W), .TS_W(TS_W), .WIN_W(WIN_W)) u0 (
    .clk(clk), .rst(rst), .win_sdr(win_sdr), .win_ddr(win_ddr),
    .a_vld(a_vld), .a_wr(a_wr), .a_ddr(a_ddr), .a_addr(a_addr), .a_ts(a_ts),
    .b_vld(b_vld), .b_wr(b_wr), .b_ddr(b_ddr), .b_addr(b_addr), .b_ts(b_ts),
    .a_busy_n(a_busy_n), .b_busy_n(b_busy_n), .a_we(a_we), .b_we(b_we),
    .a_rsel(a_rsel), .b_rsel(b_rsel), .wr_corrupt(wr_corrupt)
  );

  // reference model: packs {busy_a_n, busy_b_n, we_a, we_b, corrupt, rsel_a, rsel_b}
  function automatic logic [10:0] model();
    int gap, w, wa, wb;
    bit ba = 1, bb = 1, wea, web, cor = 0;
    int ra = 0, rb = 0;
    wea = a_vld && a_wr;
    web = b_vld && b_wr;
    gap = (int'(a_ts) - int'(b_ts)) & 32'hFFFF;
    if (gap >= 32768) gap = gap - 65536;
    wa = a_ddr ? int'(win_ddr) : int'(win_sdr);
    wb = b_ddr ? int'(win_ddr) : int'(win_sdr);
    if (a_vld && b_vld && a_addr == b_addr) begin
      if (!a_wr && b_wr) begin
        w = wb;
        if (gap > w) ra = 2; else if (gap < -w) ra = 1; else begin ra = 3; ba = 0; end
      end else if (a_wr && !b_wr) begin
        w = wa;
        if (-gap > w) rb = 2; else if (-gap < -w) rb = 1; else begin rb = 3; bb = 0; end
      end else if (a_wr && b_wr) begin
        w = (wa > wb) ? wa : wb;
        if (gap > w) begin web = 0; bb = 0; end
        else if (gap < -w) begin wea = 0; ba = 0; end
        else begin wea = 0; web = 0; ba = 0; bb = 0; cor = 1; end
      end
    end
    return {ba, bb, wea, web, cor, 2'(ra), 2'(rb)};
  endfunction

  task automatic compare(string tag);
    logic [10:0] act;
    act = {a_busy_n, b_busy_n, a_we, b_we, wr_corrupt, a_rsel, b_rsel};
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got %b expected %b (busyA busyB weA weB corrupt rselA rselB)",
               tag, act, exp_v);
    end
  endtask

  task automatic step(string tag, bit av, bit aw, bit ad, int aa, int at,
                      bit bv, bit bw, bit bd, int ba, int bt);
    a_vld = av; a_wr = aw; a_ddr = ad; a_addr = ADDR_W'(aa); a_ts = TS_W'(at);
    b_vld = bv; b_wr = bw; b_ddr = bd; b_addr = ADDR_W'(ba); b_ts = TS_W'(bt);
    exp_v = model();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    exp_v = {5'b11000, 2'd0, 2'd0};
    compare("R1 reset idle");
    rst = 1'b0;
    // R2
    step("R2 distinct addr writes", 1,1,0,5,100, 1,1,0,6,100);
    step("R2 one port idle",        1,1,0,7,100, 0,1,0,7,100);
    // R3
    step("R3 read/read same addr",  1,0,0,9,100, 1,0,0,9,100);
    // R4 / R5
    step("R4 A reads new",          1,0,0,3,100, 1,1,0,3,80);
    step("R4 B reads new",          1,1,0,3,50,  1,0,0,3,70);
    step("R4 one tick past window", 1,0,0,3,111, 1,1,0,3,100);
    step("R5 A reads old",          1,0,0,3,60,  1,1,0,3,80);
    step("R5 B reads old",          1,1,0,3,90,  1,0,0,3,70);
    // R6 / R11
    step("R6 near gap",             1,0,0,4,105, 1,1,0,4,100);
    step("R11 busy released",       0,0,0,0,0,   0,0,0,0,0);
    step("R6 gap equals window",    1,0,0,4,110, 1,1,0,4,100);
    step("R6 gap equals -window",   1,1,0,4,110, 1,0,0,4,100);
    // R7
    step("R7 ddr writer widens",    1,0,0,2,120, 1,1,1,2,100);
    step("R7 ddr writer past",      1,0,0,2,126, 1,1,1,2,100);
    step("R7 reader ddr ignored",   1,0,1,2,120, 1,1,0,2,100);
    // R8
    step("R8 A later keeps A",      1,1,0,8,200, 1,1,0,8,180);
    step("R8 B later keeps B",      1,1,0,8,180, 1,1,0,8,200);
    // R9
    step("R9 write/write near",     1,1,0,8,200, 1,1,0,8,195);
    step("R11 corrupt cleared",     1,1,0,8,200, 1,1,0,9,200);
    // R10
    step("R10 wider window wins",   1,1,1,8,220, 1,1,0,8,200);
    step("R10 past wider window",   1,1,0,8,174, 1,1,1,8,200);
    // R12
    step("R12 wrap new",            1,0,0,1,5,     1,1,0,1,65530);
    step("R12 wrap old",            1,0,0,1,65530, 1,1,0,1,5);
    step("R12 wrap near",           1,0,0,1,2,     1,1,0,1,65534);
    // mixed traffic, model compared every clock
    for (int i = 0; i < 400; i++) begin
      step("R2 R4 R5 R6 R8 R9 mixed",
           $urandom_range(0,1) == 1, $urandom_range(0,1) == 1, $urandom_range(0,1) == 1,
           $urandom_range(0,2), $urandom_range(0,65535),
           $urandom_range(0,1) == 1, $urandom_range(0,1) == 1, $urandom_range(0,1) == 1,
           $urandom_range(0,2), $urandom_range(0,65535));
      if ((i % 4) == 0) begin
        int base;
        base = $urandom_range(0,65535);
        step("R6 R9 R12 near mixed", 1, $urandom_range(0,1) == 1, $urandom_range(0,1) == 1, 1,
             base, 1, $urandom_range(0,1) == 1, $urandom_range(0,1) == 1, 1,
             base + $urandom_range(0,60) - 30);
      end
    end
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exp_v = {5'b11000, 2'd0, 2'd0};
    compare("R1 reset mid-run");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule